// File: doc/BRIEF.md
# Queue Condition Interrupt Controller

This block turns per-queue status from a queue engine into two interrupt lines. The lower bank of queues (0 to QPH-1) presents a four-bit status nibble per queue. Each lower queue has a programmable source field: two bits pick which nibble bit is watched, and a third bit inverts it. The upper bank (queues QPH to 2*QPH-1) always watches a single not-nearly-empty flag per queue; its source cannot be changed. A pending bit latches on the rising edge of a queue's watched condition while that queue is enabled. Each bank drives its own interrupt output.

Software programs the block through a simple address/data port. It writes source words and enable masks, reads pending masks, and acknowledges by writing ones to pending bits. Ranking and dispatch of the pending queues is left to the handler. The block has no state machine. Its behaviour is a per-queue edge detector feeding a sticky pending bit that software clears.

Top module: `qcic_top`

## Requirements
- R1: After reset every source field, both enable masks and both pending masks read zero, and both interrupt outputs are low.
- R2: Source words live at addresses 0 to 3. Queue q uses word q/8, bits (q%8)*4+2 down to (q%8)*4. Selector bits 1:0 pick status bit lo_status[q*4 + pick] as the watched condition.
- R3: Selector bit 2 inverts the watched condition, so with it set a queue fires when its picked status bit falls.
- R4: The fourth bit of each source field is reserved: writes to it are dropped and it reads as zero.
- R5: A pending bit sets one clock after its watched condition goes from 0 to 1, and only if the queue's enable bit was 1 in that cycle. A condition that stays high does not set it again.
- R6: Upper queue q+QPH watches hi_nne[q] directly. Its enable is address 5, bit q, and its pending is address 7, bit q.
- R7: Writing to address 6 (lower) or 7 (upper) clears the pending bits written as 1 and leaves those written as 0. Pending bits never clear without such a write.
- R8: When a set and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R9: The enable masks are at address 4 (lower) and 5 (upper). irq_lo is high exactly when some lower queue is both pending and enabled, and irq_hi likewise for the upper queues. Clearing an enable bit masks the output but keeps the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (read and write) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| lo_status | input | 128 | Four status bits per lower queue |
| hi_nne | input | 32 | Not-nearly-empty flag per upper queue |
| irq_lo | output | 1 | Interrupt for lower queues |
| irq_hi | output | 1 | Interrupt for upper queues |

## Verification
Some rules are checked on every cycle by the assertions. A pending bit never appears unless its queue was enabled. A pending bit never drops except through a write to its own pending address, and then only where the data bit was one. An interrupt output never rises while its enable mask is zero or its pending mask is empty. All registers are zero when reset ends. Other behaviour only the bench scenarios can show: which nibble bit the selector picks, the inversion firing on a falling status bit, the reserved bits reading zero, a held level not setting the bit again, and set winning over a clear in the same cycle.

// File: rtl/qcic_pkg.sv
`timescale 1ns/1ps
package qcic_pkg;
    localparam int FIELD_W         = 4;  // nibble per queue in a source word
    localparam int SEL_W           = 3;  // used bits of a field
    localparam int FIELDS_PER_WORD = 8;
    localparam int STAT_PER_Q      = 4;  // status bits per lower queue

    // Control registers follow the source words, in this order
    typedef enum logic [1:0] {
        CTL_EN_LO   = 2'd0,
        CTL_EN_HI   = 2'd1,
        CTL_PEND_LO = 2'd2,
        CTL_PEND_HI = 2'd3
    } ctl_reg_e;

    typedef struct packed {
        logic       inv;   // field bit 2
        logic [1:0] pick;  // field bits 1:0
    } src_sel_t;
endpackage

// File: rtl/qcic_src_bank.sv
`timescale 1ns/1ps
module qcic_src_bank
    import qcic_pkg::*;
#(
    parameter int QPH    = 32,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 3,
    localparam int WORDS = QPH / FIELDS_PER_WORD
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [FIELDS_PER_WORD*SEL_W-1:0]  wr_sel,
    output logic [BUS_W-1:0]                  rd_word,
    input  logic [QPH*STAT_PER_Q-1:0]         status,
    output logic [QPH-1:0]                    cond
);
    logic [QPH*SEL_W-1:0] sel_flat;

    for (genvar q = 0; q < QPH; q++) begin : g_queue
        localparam int W = q / FIELDS_PER_WORD;
        localparam int F = q % FIELDS_PER_WORD;
        src_sel_t   sel_r;
        logic [3:0] nib;

        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_r <= '0;
            else if (wr_en && addr == ADDR_W'(W))
                sel_r <= src_sel_t'(wr_sel[F*SEL_W +: SEL_W]);
        end

        assign nib                       = status[q*STAT_PER_Q +: STAT_PER_Q];
        assign cond[q]                   = nib[sel_r.pick] ^ sel_r.inv;
        assign sel_flat[q*SEL_W +: SEL_W] = sel_r;
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == ADDR_W'(w)) begin
                for (int f = 0; f < FIELDS_PER_WORD; f++)
                    rd_word[f*FIELD_W +: SEL_W] =
                        sel_flat[(w*FIELDS_PER_WORD + f)*SEL_W +: SEL_W];
            end
        end
    end
endmodule

// File: rtl/qcic_half.sv
`timescale 1ns/1ps
module qcic_half #(
    parameter int QPH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [QPH-1:0] cond,
    input  logic           en_we,
    input  logic [QPH-1:0] en_data,
    input  logic           clr_we,
    input  logic [QPH-1:0] clr_data,
    output logic [QPH-1:0] en,
    output logic [QPH-1:0] pend,
    output logic           irq
);
    logic [QPH-1:0] en_q, pend_q, cond_q;
    logic [QPH-1:0] rise, set_v, clr_v;

    assign rise  = cond & ~cond_q;
    assign set_v = rise & en_q;
    assign clr_v = clr_we ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            cond_q <= '0;
        end else begin
            cond_q <= cond;
            if (en_we)
                en_q <= en_data;
            // set applied after clear: set wins
            pend_q <= (pend_q & ~clr_v) | set_v;
        end
    end

    assign en   = en_q;
    assign pend = pend_q;
    assign irq  = |(pend_q & en_q);
endmodule

// File: rtl/qcic_top.sv
`timescale 1ns/1ps
module qcic_top
    import qcic_pkg::*;
#(
    parameter int  QPH    = 32,
    parameter int  BUS_W  = 32,
    localparam int WORDS  = QPH / FIELDS_PER_WORD,
    localparam int ADDR_W = $clog2(WORDS + 4)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [QPH*STAT_PER_Q-1:0] lo_status,
    input  logic [QPH-1:0]            hi_nne,
    output logic                      irq_lo,
    output logic                      irq_hi
);
    logic [FIELDS_PER_WORD*SEL_W-1:0] wsel;
    logic [BUS_W-1:0]                 src_rd;
    logic [QPH-1:0]                   cond_h [2];
    logic [QPH-1:0]                   en_h   [2];
    logic [QPH-1:0]                   pend_h [2];
    logic [1:0]                       irq_h;

    for (genvar f = 0; f < FIELDS_PER_WORD; f++) begin : g_wsel
        assign wsel[f*SEL_W +: SEL_W] = bus_wdata[f*FIELD_W +: SEL_W];
    end

    qcic_src_bank #(.QPH(QPH), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_sel  (wsel),
        .rd_word (src_rd),
        .status  (lo_status),
        .cond    (cond_h[0])
    );

    assign cond_h[1] = hi_nne;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int A_EN  = WORDS + int'(CTL_EN_LO) + h;
        localparam int A_CLR = WORDS + int'(CTL_PEND_LO) + h;
        logic en_we, clr_we;

        assign en_we  = bus_wr && bus_addr == ADDR_W'(A_EN);
        assign clr_we = bus_wr && bus_addr == ADDR_W'(A_CLR);

        qcic_half #(.QPH(QPH)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond     (cond_h[h]),
            .en_we    (en_we),
            .en_data  (bus_wdata[QPH-1:0]),
            .clr_we   (clr_we),
            .clr_data (bus_wdata[QPH-1:0]),
            .en       (en_h[h]),
            .pend     (pend_h[h]),
            .irq      (irq_h[h])
        );
    end

    assign irq_lo = irq_h[0];
    assign irq_hi = irq_h[1];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(WORDS))
            bus_rdata = src_rd;
        else if (bus_addr == ADDR_W'(WORDS + int'(CTL_EN_LO)))
            bus_rdata = BUS_W'(en_h[0]);
        else if (bus_addr == ADDR_W'(WORDS + int'(CTL_EN_HI)))
            bus_rdata = BUS_W'(en_h[1]);
        else if (bus_addr == ADDR_W'(WORDS + int'(CTL_PEND_LO)))
            bus_rdata = BUS_W'(pend_h[0]);
        else if (bus_addr == ADDR_W'(WORDS + int'(CTL_PEND_HI)))
            bus_rdata = BUS_W'(pend_h[1]);
    end
endmodule

// File: rtl/qcic_chk.sv
`timescale 1ns/1ps
module qcic_chk #(
    parameter int QPH    = 32,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [QPH-1:0]    wdata,
    input logic [QPH-1:0]    en_lo,
    input logic [QPH-1:0]    en_hi,
    input logic [QPH-1:0]    pend_lo,
    input logic [QPH-1:0]    pend_hi,
    input logic              irq_lo,
    input logic              irq_hi
);
    localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'(WORDS + 2);
    localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'(WORDS + 3);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_lo == '0 && en_hi == '0 && pend_lo == '0 &&
                          pend_hi == '0 && !irq_lo && !irq_hi));

    // R5
    lo_set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_lo & ~$past(pend_lo) & ~$past(en_lo)) == '0);

    // R5
    hi_set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_hi & ~$past(pend_hi) & ~$past(en_hi)) == '0);

    // R7
    lo_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_lo) & ~pend_lo) != '0) |->
            ($past(bus_wr) && $past(bus_addr) == A_PLO &&
             (($past(pend_lo) & ~pend_lo & ~$past(wdata)) == '0)));

    // R7
    hi_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_hi) & ~pend_hi) != '0) |->
            ($past(bus_wr) && $past(bus_addr) == A_PHI &&
             (($past(pend_hi) & ~pend_hi & ~$past(wdata)) == '0)));

    // R9
    lo_irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (en_lo != '0 && pend_lo != '0));

    // R9
    hi_irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (en_hi != '0 && pend_hi != '0));
endmodule

bind qcic_top qcic_chk #(.QPH(QPH), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wdata   (bus_wdata[QPH-1:0]),
    .en_lo   (en_h[0]),
    .en_hi   (en_h[1]),
    .pend_lo (pend_h[0]),
    .pend_hi (pend_h[1]),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi)
);

// File: tb/qcic_top_test.sv
`timescale 1ns/1ps
module qcic_top_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] lo_status = '0;
    logic [31:0]  hi_nne = '0;
    logic         irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        int          kind;   // 0 irq_lo, 1 irq_hi, 2 bus_rdata
        logic [31:0] exp;
    } sb_item_t;
    sb_item_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    qcic_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lo_status(lo_status),
        .hi_nne(hi_nne), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // monitor: compare expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {31'd0, irq_lo};
                1:       act = {31'd0, irq_hi};
                default: act = bus_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d: actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic exp_rd(input string r, input logic [2:0] a, input logic [31:0] e);
        bus_addr = a;
        sb.push_back('{r, 2, e});
        tick();
    endtask

    task automatic exp_irq(input string r, input bit lo, input bit hi);
        sb.push_back('{r, 0, {31'd0, lo}});
        sb.push_back('{r, 1, {31'd0, hi}});
        tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int a = 0; a < 8; a++) exp_rd("R1", 3'(a), 32'h0);
        exp_irq("R1", 1'b0, 1'b0);

        // R4 reserved bits, R2 field layout
        wr(3'd0, 32'hFFFF_FFFF);
        exp_rd("R4", 3'd0, 32'h7777_7777);
        wr(3'd3, 32'h1234_5678);
        exp_rd("R2", 3'd3, 32'h1234_5670);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h2);               // queue 0 picks status bit 2

        // R2 unpicked bit does nothing; picked bit sets
        wr(3'd4, 32'h1);
        lo_status[1] = 1'b1; tick(); tick();
        exp_rd("R2", 3'd6, 32'h0);
        lo_status[2] = 1'b1; tick();
        exp_rd("R5", 3'd6, 32'h1);
        exp_irq("R9", 1'b1, 1'b0);

        // R7 write-1-clear, zeros ignored; R5 held level no re-set
        wr(3'd6, 32'h0);
        exp_rd("R7", 3'd6, 32'h1);
        wr(3'd6, 32'h1);
        exp_rd("R7", 3'd6, 32'h0);
        tick();
        exp_rd("R5", 3'd6, 32'h0);
        exp_irq("R7", 1'b0, 1'b0);

        // R5 disabled queue ignores an edge
        wr(3'd4, 32'h0);
        lo_status[2] = 1'b0; tick();
        lo_status[2] = 1'b1; tick();
        exp_rd("R5", 3'd6, 32'h0);
        wr(3'd4, 32'h1); tick();
        exp_rd("R5", 3'd6, 32'h0);

        // R3 inverted selector on queue 1
        wr(3'd4, 32'h3);
        wr(3'd0, 32'h42);
        tick();
        exp_rd("R3", 3'd6, 32'h2);
        lo_status[4] = 1'b1; tick();
        wr(3'd6, 32'h2);
        exp_rd("R3", 3'd6, 32'h0);
        lo_status[4] = 1'b0; tick();
        exp_rd("R3", 3'd6, 32'h2);

        // R9 enable masks output, pending kept
        wr(3'd4, 32'h0);
        exp_irq("R9", 1'b0, 1'b0);
        exp_rd("R9", 3'd6, 32'h2);
        wr(3'd4, 32'h2);
        exp_irq("R9", 1'b1, 1'b0);
        wr(3'd6, 32'hFFFF_FFFF);
        exp_irq("R7", 1'b0, 1'b0);

        // R2 queue 17 picks bit 3 in word 2
        wr(3'd2, 32'h30);
        wr(3'd4, 32'h0002_0000);
        lo_status[17*4+3] = 1'b1; tick();
        exp_rd("R2", 3'd6, 32'h0002_0000);
        exp_irq("R9", 1'b1, 1'b0);
        wr(3'd6, 32'h0002_0000);

        // R6 upper bank fixed source
        wr(3'd5, 32'h20);
        hi_nne[6] = 1'b1; tick();
        exp_rd("R6", 3'd7, 32'h0);
        hi_nne[5] = 1'b1; tick();
        exp_rd("R6", 3'd7, 32'h20);
        exp_irq("R6", 1'b0, 1'b1);

        // R8 set beats clear in the same cycle
        wr(3'd7, 32'h20);
        exp_rd("R8", 3'd7, 32'h0);
        hi_nne[5] = 1'b0; tick();
        hi_nne[5] = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 32'h20;
        tick();
        bus_wr = 1'b0;
        exp_rd("R8", 3'd7, 32'h20);
        exp_irq("R8", 1'b0, 1'b1);

        tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule